// File: doc/BRIEF.md
# Parallel Five-Tuple Rule Matcher

This block is the leaf stage of a decision-tree packet classifier. It receives one wide memory word that holds a row of packed classification rules. With the word it receives the slot where the current leaf starts, the number of rules in that leaf and the five header fields of a packet. In a single cycle it compares the packet against every rule slot of the word in parallel. Slots outside the leaf window are masked off. The lowest matching slot is chosen, and on the next clock edge the block reports a hit flag, the winning rule's 16-bit rule number and its slot index.

Each rule is compressed to 160 bits. The two IP prefixes each carry a 3-bit length code. Some of the length bits are stored in address bits that the prefix itself masks off. When a leaf runs past the last slot of the word and nothing in this word matched, the block raises a continue flag. The caller then fetches the next word and searches it from slot 0. Memory reads and tree traversal belong to the caller.

Top module: `rule_matcher`

## Requirements
- R1: Slot i of `ruleWord` occupies bits [160*i+159 : 160*i]. Within a slot, the fields sit at these bit positions: rule number [15:0]; protocol value [23:16]; protocol wildcard [24]; source address [56:25]; source length code [59:57]; destination address [91:60]; destination length code [94:92]; source port low [110:95]; source port high [126:111]; destination port low [142:127]; destination port high [158:143]. Bit 159 is unused.
- R2: A port field matches when low <= packet port <= high, bounds included, for the source and destination ports independently.
- R3: The protocol field matches when its wildcard bit is 1, or when the wildcard bit is 0 and its value equals the packet protocol.
- R4: The prefix length L is rebuilt from the code c and the address bits a[2:0]. For c in 0..3, L = 8*c + a[2:0]; this form is used for L from 0 to 28. For c in 4..7, L = 25 + c, which gives 29..32. An address field matches when the top L bits of the packet address equal those of the rule address, so L = 0 matches any address.
- R5: Only slots i with startSlot <= i < startSlot + ruleCount take part in the search. A matching slot outside that window is never reported.
- R6: When several slots in the window match, the lowest slot index wins. Its rule number goes on `resRuleId` and its index on `resSlot`.
- R7: When no slot in the window matches, `resHit` is 0 and both `resRuleId` and `resSlot` are 0.
- R8: `resContinue` is 1 exactly when there is no hit and startSlot + ruleCount exceeds the number of slots per word.
- R9: Results appear on the clock edge after the one that samples `lookupValid` high. `resValid` is high for that one cycle only, and the result outputs hold their values while no lookup is issued.
- R10: While `rstN` is low, `resValid`, `resHit`, `resContinue`, `resRuleId` and `resSlot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Starts a lookup with the current inputs |
| ruleWord | input | 160*SLOTS | Packed rule slots |
| startSlot | input | SLOT_W | First slot of the leaf in this word |
| ruleCount | input | CNT_W | Rules remaining in the leaf |
| pktSrcIp | input | 32 | Packet source address |
| pktDstIp | input | 32 | Packet destination address |
| pktSrcPort | input | 16 | Packet source port |
| pktDstPort | input | 16 | Packet destination port |
| pktProto | input | 8 | Packet protocol number |
| resValid | output | 1 | One-cycle result strobe |
| resHit | output | 1 | A rule in the window matched |
| resRuleId | output | 16 | Rule number of the winner, 0 on miss |
| resSlot | output | SLOT_W | Slot index of the winner, 0 on miss |
| resContinue | output | 1 | Leaf spills into the next word with no hit |

## Verification
The first sweep is over every pattern of matching and non-matching slots in a four-slot word, crossed with every start slot and with counts from zero to past the word end. This separates window masking, lowest-slot priority and the continue flag. Port bounds are tried one below, on and one above each limit, which shows whether the comparison includes its ends. Protocol is tried exact, mismatched and wildcarded. Each prefix length from 0 to 32 is encoded in its proper form and probed twice: once with the first bit below the prefix flipped, which must still match, and once with the last prefix bit flipped, which must miss. This exposes any slip in the code decoding or the mask.

// File: rtl/rule_matcher_pkg.sv
package rule_matcher_pkg;

  localparam int RULE_W = 160;

  // one compressed rule, MSB first
  typedef struct packed {
    logic        spare;
    logic [15:0] dstPortHi;
    logic [15:0] dstPortLo;
    logic [15:0] srcPortHi;
    logic [15:0] srcPortLo;
    logic [2:0]  dstCode;
    logic [31:0] dstAddr;
    logic [2:0]  srcCode;
    logic [31:0] srcAddr;
    logic        protoAny;
    logic [7:0]  protoVal;
    logic [15:0] ruleId;
  } rule_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture the result registers this cycle
    logic windowLive;  // at least one slot lies inside the window
  } strobe_t;

  // rebuild the prefix length from code and low address bits
  function automatic logic [5:0] decodeLen(input logic [2:0] code, input logic [2:0] low);
    if (code[2]) decodeLen = 6'd29 + {4'd0, code[1:0]};
    else         decodeLen = {1'b0, code[1:0], low};
  endfunction

  function automatic logic [31:0] prefixMask(input logic [5:0] len);
    prefixMask = ~(32'hFFFF_FFFF >> len);
  endfunction

endpackage

// File: rtl/slot_match.sv
module slot_match
  import rule_matcher_pkg::*;
(
  input  rule_t       rule,
  input  logic [31:0] pktSrcIp,
  input  logic [31:0] pktDstIp,
  input  logic [15:0] pktSrcPort,
  input  logic [15:0] pktDstPort,
  input  logic [7:0]  pktProto,
  output logic        hit
);

  logic [5:0]  srcLen, dstLen;
  logic [31:0] srcMask, dstMask;
  logic        srcIpOk, dstIpOk, srcPortOk, dstPortOk, protoOk;

  always_comb begin
    srcLen    = decodeLen(rule.srcCode, rule.srcAddr[2:0]);
    dstLen    = decodeLen(rule.dstCode, rule.dstAddr[2:0]);
    srcMask   = prefixMask(srcLen);
    dstMask   = prefixMask(dstLen);
    srcIpOk   = ((pktSrcIp ^ rule.srcAddr) & srcMask) == 32'd0;
    dstIpOk   = ((pktDstIp ^ rule.dstAddr) & dstMask) == 32'd0;
    srcPortOk = (pktSrcPort >= rule.srcPortLo) && (pktSrcPort <= rule.srcPortHi);
    dstPortOk = (pktDstPort >= rule.dstPortLo) && (pktDstPort <= rule.dstPortHi);
    protoOk   = rule.protoAny || (rule.protoVal == pktProto);
    hit       = srcIpOk && dstIpOk && srcPortOk && dstPortOk && protoOk;
  end

endmodule

// File: rtl/match_datapath.sv
module match_datapath
  import rule_matcher_pkg::*;
#(
  parameter int SLOTS  = 30,
  parameter int SLOT_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [SLOTS-1:0]        slotEn,
  input  logic [SLOTS*RULE_W-1:0] ruleWord,
  input  logic [31:0]             pktSrcIp,
  input  logic [31:0]             pktDstIp,
  input  logic [15:0]             pktSrcPort,
  input  logic [15:0]             pktDstPort,
  input  logic [7:0]              pktProto,
  output logic                    anyHit,
  output logic                    resHit,
  output logic [15:0]             resRuleId,
  output logic [SLOT_W-1:0]       resSlot
);

  logic [SLOTS-1:0] rawHit;
  logic [SLOTS-1:0] liveHit;
  rule_t            rules [SLOTS];
  logic [SLOT_W-1:0] winIdx;
  logic [15:0]       winId;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign rules[i] = rule_t'(ruleWord[i*RULE_W +: RULE_W]);
    slot_match u_slot (
      .rule       (rules[i]),
      .pktSrcIp   (pktSrcIp),
      .pktDstIp   (pktDstIp),
      .pktSrcPort (pktSrcPort),
      .pktDstPort (pktDstPort),
      .pktProto   (pktProto),
      .hit        (rawHit[i])
    );
  end

  assign liveHit = rawHit & slotEn;
  assign anyHit  = strobe.windowLive && (|liveHit);

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    winIdx = '0;
    winId  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (liveHit[i]) begin
        winIdx = SLOT_W'(i);
        winId  = rules[i].ruleId;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHit    <= 1'b0;
      resRuleId <= '0;
      resSlot   <= '0;
    end else if (strobe.load) begin
      resHit    <= anyHit;
      resRuleId <= anyHit ? winId  : '0;
      resSlot   <= anyHit ? winIdx : '0;
    end
  end

  assert_win_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && anyHit) |-> slotEn[winIdx]);

  assert_win_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && anyHit) |-> ((liveHit & ((SLOTS'(1) << winIdx) - SLOTS'(1))) == '0));

endmodule

// File: rtl/match_control.sv
module match_control
  import rule_matcher_pkg::*;
#(
  parameter int SLOTS  = 30,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [SLOT_W-1:0] startSlot,
  input  logic [CNT_W-1:0]  ruleCount,
  input  logic              anyHit,
  output strobe_t           strobe,
  output logic [SLOTS-1:0]  slotEn,
  output logic              resValid,
  output logic              resContinue
);

  localparam int SUM_W = ((SLOT_W > CNT_W) ? SLOT_W : CNT_W) + 2;

  logic [SUM_W-1:0] winEnd;
  logic             spills;

  assign winEnd = SUM_W'(startSlot) + SUM_W'(ruleCount);
  assign spills = winEnd > SUM_W'(SLOTS);

  for (genvar i = 0; i < SLOTS; i++) begin : g_en
    assign slotEn[i] = (SUM_W'(i) >= SUM_W'(startSlot)) && (SUM_W'(i) < winEnd);
  end

  assign strobe.load       = lookupValid;
  assign strobe.windowLive = |slotEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      resContinue <= 1'b0;
    end else begin
      resValid <= lookupValid;
      if (lookupValid) resContinue <= spills && !anyHit;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> resValid);

  assert_valid_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(lookupValid));

  assert_empty_no_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ruleCount == '0) |-> (slotEn == '0));

endmodule

// File: rtl/rule_matcher.sv
module rule_matcher
  import rule_matcher_pkg::*;
#(
  parameter int SLOTS  = 30,
  parameter int CNT_W  = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WORD_W = SLOTS * RULE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [WORD_W-1:0] ruleWord,
  input  logic [SLOT_W-1:0] startSlot,
  input  logic [CNT_W-1:0]  ruleCount,
  input  logic [31:0]       pktSrcIp,
  input  logic [31:0]       pktDstIp,
  input  logic [15:0]       pktSrcPort,
  input  logic [15:0]       pktDstPort,
  input  logic [7:0]        pktProto,
  output logic              resValid,
  output logic              resHit,
  output logic [15:0]       resRuleId,
  output logic [SLOT_W-1:0] resSlot,
  output logic              resContinue
);

  strobe_t          strobe;
  logic [SLOTS-1:0] slotEn;
  logic             anyHit;

  match_control #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .startSlot   (startSlot),
    .ruleCount   (ruleCount),
    .anyHit      (anyHit),
    .strobe      (strobe),
    .slotEn      (slotEn),
    .resValid    (resValid),
    .resContinue (resContinue)
  );

  match_datapath #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotEn     (slotEn),
    .ruleWord   (ruleWord),
    .pktSrcIp   (pktSrcIp),
    .pktDstIp   (pktDstIp),
    .pktSrcPort (pktSrcPort),
    .pktDstPort (pktDstPort),
    .pktProto   (pktProto),
    .anyHit     (anyHit),
    .resHit     (resHit),
    .resRuleId  (resRuleId),
    .resSlot    (resSlot)
  );

  assert_hit_no_cont_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> !resContinue);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resRuleId == 16'd0 && resSlot == '0));

endmodule

// File: tb/test_rule_matcher.sv
`timescale 1ns/1ps
module test_rule_matcher;

  localparam int SLOTS = 4;
  localparam int CNT_W = 4;
  localparam int W     = SLOTS * 160;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lookupValid = 1'b0;
  logic [W-1:0] ruleWord = '0;
  logic [1:0]   startSlot = '0;
  logic [CNT_W-1:0] ruleCount = '0;
  logic [31:0]  pktSrcIp = 32'h0A00_0001;
  logic [31:0]  pktDstIp = 32'hC0A8_0105;
  logic [15:0]  pktSrcPort = 16'd1000;
  logic [15:0]  pktDstPort = 16'd80;
  logic [7:0]   pktProto = 8'd6;
  logic         resValid, resHit, resContinue;
  logic [15:0]  resRuleId;
  logic [1:0]   resSlot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rule_matcher #(.SLOTS(SLOTS), .CNT_W(CNT_W)) i_rule_matcher (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .ruleWord(ruleWord),
    .startSlot(startSlot), .ruleCount(ruleCount), .pktSrcIp(pktSrcIp),
    .pktDstIp(pktDstIp), .pktSrcPort(pktSrcPort), .pktDstPort(pktDstPort),
    .pktProto(pktProto), .resValid(resValid), .resHit(resHit),
    .resRuleId(resRuleId), .resSlot(resSlot), .resContinue(resContinue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packs a rule at the field positions of R1
  function automatic logic [159:0] mkRule(
      input logic [15:0] id, input logic pAny, input logic [7:0] pVal,
      input logic [2:0] sCode, input logic [31:0] sAddr,
      input logic [2:0] dCode, input logic [31:0] dAddr,
      input logic [15:0] sLo, input logic [15:0] sHi,
      input logic [15:0] dLo, input logic [15:0] dHi);
    logic [159:0] r;
    r = '0;
    r[15:0]    = id;
    r[23:16]   = pVal;
    r[24]      = pAny;
    r[56:25]   = sAddr;
    r[59:57]   = sCode;
    r[91:60]   = dAddr;
    r[94:92]   = dCode;
    r[110:95]  = sLo;
    r[126:111] = sHi;
    r[142:127] = dLo;
    r[158:143] = dHi;
    return r;
  endfunction

  function automatic logic [159:0] openRule(input logic [15:0] id, input logic good);
    return mkRule(id, 1'b0, good ? 8'd6 : 8'd17, 3'd0, 32'd0, 3'd0, 32'd0,
                  16'd0, 16'hFFFF, 16'd0, 16'hFFFF);
  endfunction

  task automatic look(input logic [W-1:0] w, input int st, input int cnt);
    @(negedge clk);
    ruleWord    = w;
    startSlot   = 2'(st);
    ruleCount   = CNT_W'(cnt);
    lookupValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic single(input logic [159:0] r, input logic expHit, input string tag);
    logic [W-1:0] w;
    w = '0;
    w[159:0] = r;
    for (int k = 1; k < SLOTS; k++) w[k*160 +: 160] = openRule(16'hFFFF, 1'b0);
    look(w, 0, 1);
    chk(tag, {31'd0, resHit}, {31'd0, expHit});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic [15:0]  holdId;
    int L;
    logic [31:0] base, addr, pkt;
    logic [2:0]  code;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 valid", {31'd0, resValid}, 0);
    chk("R10 hit", {31'd0, resHit}, 0);
    chk("R10 cont", {31'd0, resContinue}, 0);
    chk("R10 id", {16'd0, resRuleId}, 0);
    chk("R10 slot", {30'd0, resSlot}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R6 R7 R8: sweep match patterns, start slots and counts
    for (int m = 0; m < 16; m++) begin
      for (int st = 0; st < SLOTS; st++) begin
        for (int cnt = 0; cnt <= 6; cnt++) begin
          int   eSlot;
          logic eHit, eCont;
          for (int k = 0; k < SLOTS; k++)
            w[k*160 +: 160] = openRule(16'hA000 + 16'(k * 17), m[k]);
          eHit = 0; eSlot = 0;
          for (int k = SLOTS - 1; k >= 0; k--)
            if (k >= st && k < st + cnt && m[k]) begin eHit = 1; eSlot = k; end
          eCont = !eHit && (st + cnt > SLOTS);
          look(w, st, cnt);
          chk("R9 valid pulse", {31'd0, resValid}, 1);
          chk("R5 R6 hit", {31'd0, resHit}, {31'd0, eHit});
          chk("R6 R7 id", {16'd0, resRuleId}, eHit ? 32'hA000 + 32'(eSlot * 17) : 0);
          chk("R6 R7 slot", {30'd0, resSlot}, 32'(eSlot));
          chk("R8 continue", {31'd0, resContinue}, {31'd0, eCont});
        end
      end
    end

    // R9: outputs hold while idle
    holdId = resRuleId;
    for (int k = 0; k < SLOTS; k++) w[k*160 +: 160] = openRule(16'h1234, 1'b1);
    look(w, 1, 1);
    holdId = resRuleId;
    chk("R9 id after lookup", {16'd0, holdId}, 32'h1234);
    ruleWord = '0;
    repeat (2) @(negedge clk);
    chk("R9 idle valid", {31'd0, resValid}, 0);
    chk("R9 idle hold", {16'd0, resRuleId}, {16'd0, holdId});

    // R2: port bounds, src 100..200, dst 5..5
    for (int p = 99; p <= 201; p++) begin
      if (p == 99 || p == 100 || p == 200 || p == 201) begin
        pktSrcPort = 16'(p);
        single(mkRule(16'd7, 1'b1, 8'd0, 3'd0, 32'd0, 3'd0, 32'd0, 16'd100, 16'd200, 16'd0, 16'hFFFF),
               (p >= 100 && p <= 200), "R2 src port bound");
      end
    end
    pktSrcPort = 16'd1000;
    for (int p = 4; p <= 6; p++) begin
      pktDstPort = 16'(p);
      single(mkRule(16'd8, 1'b1, 8'd0, 3'd0, 32'd0, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd5, 16'd5),
             (p == 5), "R2 dst port bound");
    end
    pktDstPort = 16'd80;

    // R3: protocol exact, mismatch, wildcard
    single(mkRule(16'd9, 1'b0, 8'd6,  3'd0, 32'd0, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF), 1, "R3 exact");
    single(mkRule(16'd9, 1'b0, 8'd17, 3'd0, 32'd0, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF), 0, "R3 mismatch");
    single(mkRule(16'd9, 1'b1, 8'd17, 3'd0, 32'd0, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF), 1, "R3 wildcard");

    // R4 R1: every prefix length on the destination address, then the source
    base = 32'hC0A8_0105;
    for (L = 0; L <= 32; L++) begin
      addr = base;
      if (L <= 28) begin
        code = 3'(L / 8);
        addr[2:0] = 3'(L % 8);
      end else begin
        code = 3'(L - 25);
      end
      if (L < 32) begin
        pkt = base ^ (32'h1 << (31 - L));
        pktDstIp = pkt;
        single(mkRule(16'd10, 1'b1, 8'd0, 3'd0, 32'd0, code, addr, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF),
               1, "R4 dst below prefix");
        pktSrcIp = pkt;
        single(mkRule(16'd11, 1'b1, 8'd0, code, addr, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF),
               1, "R4 src below prefix");
      end
      if (L > 0) begin
        pkt = base ^ (32'h1 << (32 - L));
        pktDstIp = pkt;
        single(mkRule(16'd10, 1'b1, 8'd0, 3'd0, 32'd0, code, addr, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF),
               0, "R4 dst inside prefix");
        pktSrcIp = pkt;
        single(mkRule(16'd11, 1'b1, 8'd0, code, addr, 3'd0, 32'd0, 16'd0, 16'hFFFF, 16'd0, 16'hFFFF),
               0, "R4 src inside prefix");
      end
      pktSrcIp = 32'h0A00_0001;
      pktDstIp = base;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule